// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Address Generator

This block produces the paired read and write address streams for one rectangular DMA block move. An example is lifting a tile out of a frame buffer and placing it into a packed buffer elsewhere. Software-side logic supplies a source base, a destination base, the number of word beats per row, the number of rows, and a stride plus a direction bit for each side. A one-cycle start request then launches the walk. The generator presents one read-address/write-address pair per beat on a valid/ready handshake. It moves to the next pair only when the pair is accepted.

Within a row, both addresses climb by one word (4 bytes) per beat. When a row ends, each side jumps to its own previous row-start address, moved up or down by its own stride. The gap between rows on each side is therefore set by that side's stride alone, and the two sides can use different pitches. This is what allows a gather from a wide pitch into a narrow one, or the reverse. When the final beat is accepted, the block drops valid, drops busy and pulses done.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, and after any reset asserted mid-transfer, `busy`, `beat_valid` and `done` are all low.
- R2: A start accepted while idle raises `beat_valid` and `busy` on the following cycle. The first pair is `src_base` and `dst_base`, each with its two least significant bits cleared.
- R3: Each accepted beat that is not the last of its row advances both `rd_addr` and `wr_addr` by 4.
- R4: After the last beat of a row, each side restarts at its previous row-start address plus its stride when its direction bit is 0, or minus its stride when the bit is 1. The two sides do this independently.
- R5: All address arithmetic wraps modulo 2^32, both inside a row and at a row jump.
- R6: A transfer with `row_beats` = X and `row_count` = Y (both nonzero) presents exactly X×Y accepted beats, and `beat_valid` is high only while `busy` is high.
- R7: While `beat_valid` is high and `beat_ready` is low, `beat_valid`, `rd_addr` and `wr_addr` hold their values.
- R8: `done` is high for exactly one cycle, in the cycle after the final beat is accepted. `busy` falls at that same edge, so `done` and `busy` are never high together.
- R9: A start request while `busy` is high is ignored: the running transfer keeps its addresses and its beat count.
- R10: A start with `row_beats` = 0 or `row_count` = 0 presents no beat, leaves `busy` low, and pulses `done` in the next cycle.
- R11: Every presented `rd_addr` and `wr_addr` has its two least significant bits at zero, even when the base is misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only while idle |
| src_base | input | 32 | Source byte base address |
| dst_base | input | 32 | Destination byte base address |
| row_beats | input | 16 | Word beats per row |
| row_count | input | 16 | Number of rows |
| src_stride | input | 32 | Source row-to-row byte offset |
| src_dir | input | 1 | 0 adds the source stride, 1 subtracts it |
| dst_stride | input | 32 | Destination row-to-row byte offset |
| dst_dir | input | 1 | 0 adds the destination stride, 1 subtracts it |
| beat_valid | output | 1 | Address pair is presented |
| beat_ready | input | 1 | Consumer accepts the presented pair |
| rd_addr | output | 32 | Source byte address of the current beat |
| wr_addr | output | 32 | Destination byte address of the current beat |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume the configuration inputs are sampled only at the edge where a start is accepted. They also assume the consumer may hold `beat_ready` low for any number of cycles but never needs a pair withdrawn. The stimulus therefore changes the bases, counts and strides only while driving a start. It varies `beat_ready` with a per-case stall pattern, so that stalls land both inside rows and on row boundaries. Strides are kept word-aligned, while one case uses misaligned bases to exercise the forced clearing of the low bits.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  // stride direction encoding shared by both address sides
  typedef enum logic {
    STEP_ADD = 1'b0,
    STEP_SUB = 1'b1
  } step_dir_e;

  localparam int unsigned SIDES   = 2;
  localparam int unsigned SIDE_RD = 0;
  localparam int unsigned SIDE_WR = 1;
endpackage

// File: rtl/dma2d_beat_ctr.sv
module dma2d_beat_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] x_len,
  input  logic [CW-1:0] y_len,
  input  logic          adv,
  output logic          last_beat,
  output logic          last_row
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] xlen_q;
  logic [CW-1:0] x_q;
  logic [CW-1:0] y_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xlen_q <= '0;
      x_q    <= '0;
      y_q    <= '0;
    end else if (load) begin
      xlen_q <= x_len;
      x_q    <= x_len;
      y_q    <= y_len;
    end else if (adv) begin
      if (x_q == ONE) begin
        x_q <= xlen_q;
        y_q <= y_q - ONE;
      end else begin
        x_q <= x_q - ONE;
      end
    end
  end

  assign last_beat = (x_q == ONE);
  assign last_row  = (y_q == ONE);
endmodule

// File: rtl/dma2d_addr_side.sv
module dma2d_addr_side #(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stride,
  input  logic          dir,
  input  logic          beat_step,
  input  logic          row_step,
  output logic [AW-1:0] addr
);
  import dma2d_pkg::*;

  localparam logic [AW-1:0] BEAT_INC   = AW'(BEAT_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(BEAT_BYTES - 1));

  logic [AW-1:0] row_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] stride_q;
  step_dir_e     dir_q;
  logic [AW-1:0] stride_a;
  logic [AW-1:0] next_row;

  assign stride_a = stride_q & ALIGN_MASK;
  assign next_row = (dir_q == STEP_SUB) ? (row_q - stride_a) : (row_q + stride_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q    <= '0;
      addr_q   <= '0;
      stride_q <= '0;
      dir_q    <= STEP_ADD;
    end else if (load) begin
      row_q    <= base & ALIGN_MASK;
      addr_q   <= base & ALIGN_MASK;
      stride_q <= stride;
      dir_q    <= step_dir_e'(dir);
    end else if (row_step) begin
      row_q  <= next_row;
      addr_q <= next_row;
    end else if (beat_step) begin
      addr_q <= addr_q + BEAT_INC;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] row_beats,
  input  logic [CW-1:0] row_count,
  input  logic [AW-1:0] src_stride,
  input  logic          src_dir,
  input  logic [AW-1:0] dst_stride,
  input  logic          dst_dir,
  output logic          beat_valid,
  input  logic          beat_ready,
  output logic [AW-1:0] rd_addr,
  output logic [AW-1:0] wr_addr,
  output logic          busy,
  output logic          done
);
  import dma2d_pkg::*;

  logic busy_q, valid_q, done_q;
  logic start_ok, zero_len, load, hs;
  logic last_beat, last_row;
  logic row_step, beat_step, finish;

  logic [AW-1:0] side_base   [SIDES];
  logic [AW-1:0] side_stride [SIDES];
  logic          side_dir    [SIDES];
  logic [AW-1:0] side_addr   [SIDES];

  assign start_ok  = start && !busy_q;
  assign zero_len  = (row_beats == '0) || (row_count == '0);
  assign load      = start_ok && !zero_len;
  assign hs        = valid_q && beat_ready;
  assign finish    = hs && last_beat && last_row;
  assign row_step  = hs && last_beat && !last_row;
  assign beat_step = hs && !last_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        if (zero_len) begin
          done_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          valid_q <= 1'b1;
        end
      end else if (finish) begin
        busy_q  <= 1'b0;
        valid_q <= 1'b0;
        done_q  <= 1'b1;
      end
    end
  end

  dma2d_beat_ctr #(.CW(CW)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .x_len     (row_beats),
    .y_len     (row_count),
    .adv       (hs),
    .last_beat (last_beat),
    .last_row  (last_row)
  );

  assign side_base[SIDE_RD]   = src_base;
  assign side_base[SIDE_WR]   = dst_base;
  assign side_stride[SIDE_RD] = src_stride;
  assign side_stride[SIDE_WR] = dst_stride;
  assign side_dir[SIDE_RD]    = src_dir;
  assign side_dir[SIDE_WR]    = dst_dir;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dma2d_addr_side #(.AW(AW), .BEAT_BYTES(BEAT_BYTES)) u_side (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .base      (side_base[s]),
      .stride    (side_stride[s]),
      .dir       (side_dir[s]),
      .beat_step (beat_step),
      .row_step  (row_step),
      .addr      (side_addr[s])
    );
  end

  assign rd_addr    = side_addr[SIDE_RD];
  assign wr_addr    = side_addr[SIDE_WR];
  assign beat_valid = valid_q;
  assign busy       = busy_q;
  assign done       = done_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int BEAT_BYTES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic [AW-1:0] src_base,
  input logic [AW-1:0] dst_base,
  input logic [CW-1:0] row_beats,
  input logic [CW-1:0] row_count,
  input logic          beat_valid,
  input logic          beat_ready,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] wr_addr,
  input logic          busy,
  input logic          done
);
  localparam logic [AW-1:0] MASK = ~(AW'(BEAT_BYTES - 1));

  assert_first_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && row_beats != '0 && row_count != '0) |=>
      (beat_valid && busy && rd_addr == ($past(src_base) & MASK) && wr_addr == ($past(dst_base) & MASK)));

  assert_valid_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> busy);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(rd_addr) && $stable(wr_addr)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  assert_busy_needs_start_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  assert_zero_len_R10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (row_beats == '0 || row_count == '0)) |=> (done && !busy && !beat_valid));

  assert_aligned_R11: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (rd_addr[1:0] == 2'b00 && wr_addr[1:0] == 2'b00));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW), .CW(CW), .BEAT_BYTES(BEAT_BYTES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .src_base   (src_base),
  .dst_base   (dst_base),
  .row_beats  (row_beats),
  .row_count  (row_count),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .rd_addr    (rd_addr),
  .wr_addr    (wr_addr),
  .busy       (busy),
  .done       (done)
);

// File: tb/tb_dma2d_addr_gen.sv
module tb_dma2d_addr_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0, src_stride = '0, dst_stride = '0;
  logic [15:0] row_beats = '0, row_count = '0;
  logic        src_dir = 1'b0, dst_dir = 1'b0;
  logic        beat_ready = 1'b0;
  logic        beat_valid, busy, done;
  logic [31:0] rd_addr, wr_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma2d_addr_gen dut (
    .clk(clk), .rst(rst), .start(start),
    .src_base(src_base), .dst_base(dst_base),
    .row_beats(row_beats), .row_count(row_count),
    .src_stride(src_stride), .src_dir(src_dir),
    .dst_stride(dst_stride), .dst_dir(dst_dir),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .rd_addr(rd_addr), .wr_addr(wr_addr),
    .busy(busy), .done(done)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] x;
    logic [15:0] y;
    logic [31:0] ss;
    logic        sd;
    logic [31:0] ds;
    logic        dd;
    logic [31:0] last_s;
    logic [31:0] last_d;
    logic [1:0]  stall;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 16'd4, 16'd8, 32'h20,  1'b0, 32'h10, 1'b0, 32'h0000_00EC, 32'h0000_007C, 2'd0},
    '{32'h0000_1000, 32'h0000_2000, 16'd2, 16'd3, 32'h100, 1'b1, 32'h40, 1'b0, 32'h0000_0E04, 32'h0000_2084, 2'd1},
    '{32'hFFFF_FFF8, 32'h0000_0010, 16'd3, 16'd2, 32'h8,   1'b0, 32'h20, 1'b1, 32'h0000_0008, 32'hFFFF_FFF8, 2'd2},
    '{32'h0000_0103, 32'h0000_0206, 16'd1, 16'd4, 32'h10,  1'b0, 32'h4,  1'b0, 32'h0000_0130, 32'h0000_0210, 2'd3},
    '{32'h0000_0044, 32'h0000_0088, 16'd1, 16'd1, 32'h0,   1'b0, 32'h0,  1'b1, 32'h0000_0044, 32'h0000_0088, 2'd1}
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [31:0] ms, msr, md, mdr, ls, ld;
    int beats, total, xi;
    logic rdy, seen;
    ms = v.src & ~32'h3; msr = ms;
    md = v.dst & ~32'h3; mdr = md;
    total = int'(v.x) * int'(v.y);
    beats = 0; xi = 0; seen = 1'b0; ls = '0; ld = '0;
    @(negedge clk);
    src_base = v.src; dst_base = v.dst; row_beats = v.x; row_count = v.y;
    src_stride = v.ss; src_dir = v.sd; dst_stride = v.ds; dst_dir = v.dd;
    beat_ready = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(beat_valid == 1'b1, "R2 valid after start", 32'(beat_valid), 32'd1);
    for (int k = 0; k < 4000; k++) begin
      if (done) begin
        seen = 1'b1;
        check(beats == total, "R6 beat count", 32'(beats), 32'(total));
        check(busy == 1'b0 && beat_valid == 1'b0, "R8 idle at done", {30'd0, busy, beat_valid}, 32'd0);
        break;
      end
      check(beats < total, "R8 done one cycle after last beat", 32'(beats), 32'(total));
      check(busy == 1'b1 && beat_valid == 1'b1, "R6 valid while busy", {30'd0, busy, beat_valid}, 32'd3);
      check(rd_addr == ms, "R3,R4,R5,R7,R11 rd_addr", rd_addr, ms);
      check(wr_addr == md, "R3,R4,R5,R7,R11 wr_addr", wr_addr, md);
      rdy = ((k % 4) >= int'(v.stall));
      beat_ready = rdy;
      @(posedge clk);
      @(negedge clk);
      if (rdy) begin
        ls = ms; ld = md;
        beats++; xi++;
        if (xi == int'(v.x)) begin
          xi = 0;
          msr = v.sd ? msr - v.ss : msr + v.ss;
          mdr = v.dd ? mdr - v.ds : mdr + v.ds;
          ms = msr; md = mdr;
        end else begin
          ms = ms + 32'd4; md = md + 32'd4;
        end
      end
    end
    beat_ready = 1'b0;
    check(seen, "R8 done seen", 32'(seen), 32'd1);
    check(ls == v.last_s, "R4,R5 final rd_addr", ls, v.last_s);
    check(ld == v.last_d, "R4,R5 final wr_addr", ld, v.last_d);
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic zero_case(input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    row_beats = x; row_count = y; src_base = 32'h700; dst_base = 32'h800; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1, "R10 done next cycle", 32'(done), 32'd1);
    check(busy == 1'b0 && beat_valid == 1'b0, "R10 no beat no busy", {30'd0, busy, beat_valid}, 32'd0);
    @(negedge clk);
    check(done == 1'b0 && beat_valid == 1'b0, "R10 quiet after", {30'd0, done, beat_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int beats;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", 32'(busy), 32'd0);
    check(beat_valid == 1'b0, "R1 valid after reset", 32'(beat_valid), 32'd0);
    check(done == 1'b0, "R1 done after reset", 32'(done), 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    zero_case(16'd0, 16'd5);
    zero_case(16'd3, 16'd0);

    // R9: start during a transfer is ignored
    @(negedge clk);
    src_base = 32'h500; dst_base = 32'h600; row_beats = 16'd2; row_count = 16'd2;
    src_stride = 32'h40; dst_stride = 32'h40; src_dir = 1'b0; dst_dir = 1'b0;
    beat_ready = 1'b0; start = 1'b1;
    @(negedge clk);
    src_base = 32'h900; dst_base = 32'hA00; row_beats = 16'd7;
    @(negedge clk);
    start = 1'b0;
    check(rd_addr == 32'h500, "R9 rd_addr kept", rd_addr, 32'h500);
    check(wr_addr == 32'h600, "R9 wr_addr kept", wr_addr, 32'h600);
    beat_ready = 1'b1;
    beats = 0;
    for (int k = 0; k < 50; k++) begin
      if (done) break;
      if (beat_valid) beats++;
      @(negedge clk);
    end
    beat_ready = 1'b0;
    check(beats == 4, "R9 beat count kept", 32'(beats), 32'd4);
    @(negedge clk);
    check(busy == 1'b0 && beat_valid == 1'b0, "R9 idle after", {30'd0, busy, beat_valid}, 32'd0);

    // R1: reset mid-transfer
    @(negedge clk);
    row_beats = 16'd3; row_count = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(beat_valid == 1'b1, "R2 valid before reset", 32'(beat_valid), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0 && beat_valid == 1'b0 && done == 1'b0, "R1 mid-transfer reset",
          {29'd0, busy, beat_valid, done}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule